// File: doc/BRIEF.md
# SPI Status-Register Slave

This block is the serial front end of a small supervisor device. An external SPI master selects it with an active-low chip select and clocks it in mode 0. The first byte of each frame is an opcode. Depending on the opcode, an address byte and data bytes follow, all most significant bit first. The block keeps a configuration/status byte that holds three things: a stored write-protect enable, a two-bit watchdog period select and a two-bit block-protect field. Neighbouring logic reads these fields from dedicated outputs. Byte access to the device memory goes through a simple register-file port: a combinational read and a one-cycle write strobe.

All serial pins are brought into the system clock domain through synchronizers. The block then works on the detected clock edges. After reset it stays deaf until chip select has been seen going from high to low. The serial data output has a separate enable, so that the pad is undriven whenever the device is not selected. When the stored enable bit is set and the active-low protect pin is pulled low, the configuration fields are frozen.

Top module: `spi_sup_slave`

## Requirements
- R1: `spi_miso_oe` is 0 whenever `spi_cs_n` is high, and 1 while the armed device is selected.
- R2: After reset, traffic has no effect and `spi_miso_oe` stays 0 until a high-to-low transition of `spi_cs_n` has been seen. A frame already in progress when reset is released is ignored.
- R3: Mode 0 framing applies. `spi_mosi` is sampled on rising SCK. `spi_miso` changes after falling SCK and is valid for the next rising edge. Every byte travels most significant bit first.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte with this layout: bit 7 = protect enable, bit 6 = 0, bits 5:4 = watchdog select, bits 3:2 = block protect, bit 1 = write-enable latch, bit 0 = 0.
- R5: Opcode 0x01 (status write) has no effect while the write-enable latch is clear.
- R6: With the latch set, the first data byte after opcode 0x01 loads bits 7, 5:4 and 3:2 into the configuration, and the latch then clears. After reset the configuration is all zero.
- R7: While protect enable is 1 and `spi_wp_n` is 0, a status write leaves all configuration fields unchanged, but it still clears the latch.
- R8: While protect enable is 0, the level of `spi_wp_n` has no effect on status writes.
- R9: Raising `spi_cs_n` ends the frame. A partly shifted byte is discarded, and the next frame starts a fresh byte count.
- R10: Opcode 0x03 followed by an address byte returns memory data from that address. Each further byte returns the next address, wrapping from the top address to 0.
- R11: Opcode 0x02, address, data writes one byte. This happens only if the latch is set: `mem_we` then pulses for one cycle with the address and data, and the latch clears. Further bytes in the frame write nothing.
- R12: Block protect suppresses the memory write. Value 01 protects addresses whose top two bits are 11, value 10 protects addresses whose top bit is 1, and value 11 protects all addresses.
- R13: During opcode 0x05, every byte after the opcode returns the current status byte again.
- R14: `wd_period_sel` and `blk_prot` always equal the stored watchdog and block-protect fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from master |
| spi_wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_rdata | input | DW | Combinational memory read data |
| wd_period_sel | output | 2 | Stored watchdog period select |
| blk_prot | output | 2 | Stored block-protect field |

## Verification
Status writes are tried four ways: with the latch set, with it clear, with the pin low and the enable clear, and with both pin and enable active. Together these separate the latch gating from the pin lock, and the pin lock from a plain ignored pin. Memory writes are aimed at addresses just inside and just outside the protected quarter. This shows a quarter boundary apart from a half boundary, and an unexpected strobe is caught by the write scoreboard. Other cases exercise framing edge cases: frames cut after seven bits and after three bits, a frame running while reset is released, a read that wraps past the top address, and repeated status bytes.

// File: rtl/spi_sup_pkg.sv
package spi_sup_pkg;

  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int ST_PEN = 7;
  localparam int ST_WDH = 5;
  localparam int ST_WDL = 4;
  localparam int ST_BPH = 3;
  localparam int ST_BPL = 2;
  localparam int ST_WEL = 1;

  typedef struct packed {
    logic       pen;
    logic [1:0] wd;
    logic [1:0] bp;
  } cfg_t;

  function automatic logic [7:0] status_byte(input cfg_t c, input logic wel);
    logic [7:0] s;
    s         = '0;
    s[ST_PEN] = c.pen;
    s[ST_WDH:ST_WDL] = c.wd;
    s[ST_BPH:ST_BPL] = c.bp;
    s[ST_WEL] = wel;
    return s;
  endfunction

  function automatic cfg_t cfg_from_byte(input logic [7:0] b);
    cfg_t c;
    c.pen = b[ST_PEN];
    c.wd  = b[ST_WDH:ST_WDL];
    c.bp  = b[ST_BPH:ST_BPL];
    return c;
  endfunction

endpackage

// File: rtl/spi_sup_sync.sv
module spi_sup_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_sup_frame.sv
module spi_sup_frame #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_idx
);

  localparam int                CNT_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0]  IDX_MAX = {IDX_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [BYTE_W-1:0] sh_q,   sh_d;
  logic              stb_q,  stb_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [IDX_W-1:0]  idxo_q, idxo_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    stb_d  = 1'b0;
    data_d = data_q;
    idx_d  = idx_q;
    idxo_d = idxo_q;
    if (!active) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (sck_rise) begin
      sh_d = {sh_q[BYTE_W-2:0], mosi};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        stb_d  = 1'b1;
        data_d = sh_d;
        idxo_d = idx_q;
        if (idx_q != IDX_MAX) idx_d = idx_q + IDX_W'(1);
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      stb_q  <= 1'b0;
      data_q <= '0;
      idx_q  <= '0;
      idxo_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      stb_q  <= stb_d;
      data_q <= data_d;
      idx_q  <= idx_d;
      idxo_q <= idxo_d;
    end
  end

  assign byte_stb  = stb_q;
  assign byte_data = data_q;
  assign byte_idx  = idxo_q;

  // R9: a completed byte only comes out of a frame that was still open
  assert_byte_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(active));

  // R9: one strobe per byte
  assert_byte_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

endmodule

// File: rtl/spi_sup_ctrl.sv
module spi_sup_ctrl
  import spi_sup_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             sck_fall,
  input  logic             byte_stb,
  input  logic [DW-1:0]    byte_data,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic             wp_n,
  input  logic [DW-1:0]    mem_rdata,
  output logic             miso,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic [1:0]       wd_sel,
  output logic [1:0]       bp_sel
);

  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(2);

  logic [DW-1:0] op_q,    op_d;
  logic          wel_q,   wel_d;
  cfg_t          cfg_q,   cfg_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic          fetch_q, fetch_d;
  logic [DW-1:0] tx_q,    tx_d;
  logic          miso_q,  miso_d;
  logic          we_q,    we_d;
  logic [DW-1:0] wdat_q,  wdat_d;

  logic          lock;
  logic          prot;
  logic [7:0]    stat;

  assign lock = cfg_q.pen & ~wp_n;
  assign stat = status_byte(cfg_q, wel_q);

  always_comb begin
    case (cfg_q.bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &addr_q[AW-1:AW-2];
      2'b10:   prot = addr_q[AW-1];
      default: prot = 1'b1;
    endcase
  end

  always_comb begin
    op_d    = op_q;
    wel_d   = wel_q;
    cfg_d   = cfg_q;
    addr_d  = addr_q;
    fetch_d = 1'b0;
    tx_d    = tx_q;
    miso_d  = miso_q;
    we_d    = 1'b0;
    wdat_d  = wdat_q;
    if (!active) begin
      op_d   = OP_NONE;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (sck_fall) begin
        miso_d = tx_q[DW-1];
        tx_d   = {tx_q[DW-2:0], 1'b0};
      end
      if (fetch_q) tx_d = mem_rdata;
      if (byte_stb) begin
        if (byte_idx == '0) begin
          op_d = byte_data;
          case (byte_data)
            OP_WREN: wel_d = 1'b1;
            OP_WRDI: wel_d = 1'b0;
            OP_RDSR: tx_d  = stat;
            default: ;
          endcase
        end else begin
          case (op_q)
            OP_RDSR: tx_d = stat;
            OP_WRSR: begin
              if (byte_idx == IDX_ADDR && wel_q) begin
                wel_d = 1'b0;
                if (!lock) cfg_d = cfg_from_byte(byte_data);
              end
            end
            OP_READ: begin
              if (byte_idx == IDX_ADDR) addr_d = byte_data[AW-1:0];
              else                      addr_d = addr_q + AW'(1);
              fetch_d = 1'b1;
            end
            OP_WRITE: begin
              if (byte_idx == IDX_ADDR) begin
                addr_d = byte_data[AW-1:0];
              end else if (byte_idx == IDX_DATA && wel_q) begin
                wel_d = 1'b0;
                if (!prot) begin
                  we_d   = 1'b1;
                  wdat_d = byte_data;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      wel_q   <= 1'b0;
      cfg_q   <= '0;
      addr_q  <= '0;
      fetch_q <= 1'b0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
      we_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      op_q    <= op_d;
      wel_q   <= wel_d;
      cfg_q   <= cfg_d;
      addr_q  <= addr_d;
      fetch_q <= fetch_d;
      tx_q    <= tx_d;
      miso_q  <= miso_d;
      we_q    <= we_d;
      wdat_q  <= wdat_d;
    end
  end

  assign miso      = miso_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign mem_we    = we_q;
  assign wd_sel    = cfg_q.wd;
  assign bp_sel    = cfg_q.bp;

  // R7: while pin and enable both lock, the configuration cannot move
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cfg_q));

  // R6: a configuration change needs the latch one cycle earlier
  assert_cfg_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(wel_q));

  // R11: a memory write consumes the latch
  assert_we_consumes_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ($past(wel_q) && !wel_q));

  // R11: write strobe lasts one cycle
  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R12: no strobe for a protected address
  assert_we_unprotected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> !$past(prot));

endmodule

// File: rtl/spi_sup_slave.sv
module spi_sup_slave
  import spi_sup_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_wp_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    wd_period_sel,
  output logic [1:0]    blk_prot
);

  localparam int PIN_W = 4;
  localparam int IDX_W = 2;
  // pin order {wp_n, mosi, sck, cs_n}; cs_n starts low so that a frame
  // open at reset release never yields a falling edge
  localparam logic [PIN_W-1:0] PIN_RST = 4'b1000;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic [PIN_W-1:0] pins;

  spi_sup_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   ({spi_wp_n, spi_mosi, spi_sck, spi_cs_n}),
    .dout  (pins)
  );

  logic cs_lvl, sck_lvl, mosi_lvl, wp_lvl;
  assign cs_lvl   = pins[0];
  assign sck_lvl  = pins[1];
  assign mosi_lvl = pins[2];
  assign wp_lvl   = pins[3];

  logic cs_prev_q,  sck_prev_q;
  logic armed_q,    armed_d;
  logic cs_fall, sck_rise, sck_fall, active;

  assign cs_fall  =  cs_prev_q & ~cs_lvl;
  assign sck_rise = ~sck_prev_q &  sck_lvl;
  assign sck_fall =  sck_prev_q & ~sck_lvl;
  assign armed_d  = armed_q | cs_fall;
  assign active   = armed_q & ~cs_lvl;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      cs_prev_q  <= cs_lvl;
      sck_prev_q <= sck_lvl;
      armed_q    <= armed_d;
    end
  end

  logic             byte_stb;
  logic [DW-1:0]    byte_data;
  logic [IDX_W-1:0] byte_idx;

  spi_sup_frame #(
    .BYTE_W (DW),
    .IDX_W  (IDX_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .active    (active),
    .sck_rise  (sck_rise),
    .mosi      (mosi_lvl),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .byte_idx  (byte_idx)
  );

  spi_sup_ctrl #(
    .AW    (AW),
    .DW    (DW),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .active    (active),
    .sck_fall  (sck_fall),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .byte_idx  (byte_idx),
    .wp_n      (wp_lvl),
    .mem_rdata (mem_rdata),
    .miso      (spi_miso),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .wd_sel    (wd_period_sel),
    .bp_sel    (blk_prot)
  );

  assign spi_miso_oe = active;

  // R2: nothing leaves the block before the first select edge
  assert_quiet_until_armed_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !armed_q |-> (!spi_miso_oe && !mem_we && !spi_miso));

  // R1: a deselected pin level keeps the pad undriven
  assert_hiz_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_lvl |-> !spi_miso_oe);

endmodule

// File: tb/spi_sup_slave_bench.sv
module spi_sup_slave_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sck, mosi, wp_n;
  logic       miso, miso_oe;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [1:0] wd_sel, bp;

  int checks = 0;
  int errors = 0;

  logic [7:0]  bmem [256];
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;

  assign mem_rdata = bmem[mem_addr];

  spi_sup_slave u_spi_sup_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_cs_n      (cs_n),
    .spi_sck       (sck),
    .spi_mosi      (mosi),
    .spi_wp_n      (wp_n),
    .spi_miso      (miso),
    .spi_miso_oe   (miso_oe),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_we        (mem_we),
    .mem_rdata     (mem_rdata),
    .wd_period_sel (wd_sel),
    .blk_prot      (bp)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write scoreboard monitor (R11, R12)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11/R12 unexpected write actual=%0h expected=none",
                 {mem_addr, mem_wdata});
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          errors++;
          $display("FAIL R11 write actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
        end
      end
      bmem[mem_addr] = mem_wdata;
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      half();
      sck = 1'b1;
      rx[i] = miso;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    half();
  endtask

  task automatic desel();
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, 8, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    sel(); xfer(8'h05, 8, r); xfer(8'h00, 8, st); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, 8, r); xfer(v, 8, r); desel();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    sel(); xfer(8'h02, 8, r); xfer(a, 8, r); xfer(d, 8, r); desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st, a, b, c, r;
    for (int i = 0; i < 256; i++) bmem[i] = init_val(i);
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: frame open across reset release is ignored
    chk("R2 oe before arm", miso_oe, 0);
    chk("R14 reset wd", wd_sel, 0);
    chk("R14 reset bp", bp, 0);
    xfer(8'h06, 8, r);
    chk("R2 oe unarmed frame", miso_oe, 0);
    cs_n = 1'b1; half(); half();
    chk("R1 oe deselected", miso_oe, 0);
    rdsr(st);
    chk("R2 WREN before arm ignored", st, 8'h00);

    // R5: status write without latch
    wrsr(8'h3C);
    rdsr(st);
    chk("R5 status unchanged", st, 8'h00);

    // R4: latch set / clear
    cmd1(8'h06); rdsr(st);
    chk("R4 WEL set", st, 8'h02);
    cmd1(8'h04); rdsr(st);
    chk("R4 WEL cleared", st, 8'h00);

    // R6: status write with latch
    cmd1(8'h06); wrsr(8'h3C); rdsr(st);
    chk("R3 R6 status loaded", st, 8'h3C);
    chk("R14 wd out", wd_sel, 2'd3);
    chk("R14 bp out", bp, 2'd3);

    // R13: repeated status, R1 enable inside frame
    sel(); xfer(8'h05, 8, r); xfer(8'h00, 8, a); xfer(8'h00, 8, b);
    chk("R1 oe selected", miso_oe, 1);
    desel();
    chk("R13 first status", a, 8'h3C);
    chk("R13 second status", b, 8'h3C);

    // R12: everything protected
    cmd1(8'h06); wr(8'h10, 8'h11);
    rdsr(st);
    chk("R11 WEL cleared after blocked write", st, 8'h3C);

    // R12: top quarter only
    cmd1(8'h06); wrsr(8'h04); rdsr(st);
    chk("R6 bp quarter", st, 8'h04);
    cmd1(8'h06); wr(8'hC5, 8'h77);
    cmd1(8'h06); exp_q.push_back({8'h85, 8'h5A}); wr(8'h85, 8'h5A);
    // R11: no latch, no write
    wr(8'h40, 8'h99);

    // R10: sequential read
    sel(); xfer(8'h03, 8, r); xfer(8'h20, 8, r);
    xfer(8'h00, 8, a); xfer(8'h00, 8, b); xfer(8'h00, 8, c); desel();
    chk("R10 read 0x20", a, init_val(8'h20));
    chk("R10 read 0x21", b, init_val(8'h21));
    chk("R10 read 0x22", c, init_val(8'h22));
    sel(); xfer(8'h03, 8, r); xfer(8'h85, 8, r); xfer(8'h00, 8, a); desel();
    chk("R11 written byte read back", a, 8'h5A);
    chk("R11 blocked address untouched", bmem[8'hC5], init_val(8'hC5));
    sel(); xfer(8'h03, 8, r); xfer(8'hFF, 8, r);
    xfer(8'h00, 8, a); xfer(8'h00, 8, b); desel();
    chk("R10 read top", a, init_val(8'hFF));
    chk("R10 read wraps", b, init_val(0));

    // R8: pin low, enable clear
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h90); rdsr(st);
    chk("R8 write with pin low", st, 8'h90);
    chk("R14 wd follows", wd_sel, 2'd1);

    // R7: locked
    cmd1(8'h06); wrsr(8'h0C); rdsr(st);
    chk("R7 locked status held", st, 8'h90);
    chk("R7 bp out held", bp, 2'd0);
    wp_n = 1'b1;
    cmd1(8'h06); wrsr(8'h08); rdsr(st);
    chk("R7 unlocked by pin", st, 8'h08);

    // R9: aborted frames
    sel(); xfer(8'h06, 7, r); desel();
    rdsr(st);
    chk("R9 partial opcode dropped", st, 8'h08);
    sel(); xfer(8'hFF, 3, r); desel();
    cmd1(8'h06); rdsr(st);
    chk("R9 fresh count after abort", st, 8'h0A);

    repeat (20) @(negedge clk);
    chk("R11 all expected writes seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule